// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two threshold offsets that a deep synchronous FIFO compares against its fill level: the almost-empty offset and the almost-full offset. Each offset is 16 bits wide and is held as a low byte and a high byte. The four byte registers can be filled in three ways. One is byte by byte from a 9-bit data bus. Another is bit by bit from a serial input. The third is from one of two default sets that are chosen when master reset is applied. Software or a test controller can also read the registers back one byte at a time on the read clock.

The same four control pins also drive ordinary FIFO memory traffic. When the load select pin is high, the write and read enables produce memory write and read strobes. When it is low, the enables step the offset sequencers instead. The levels on the load select and serial enable pins during master reset choose the default values and the programming method. That choice then holds until the next master reset. The FIFO storage array and the flag comparators sit outside this block.

Top module: `fifo_offset_loader`

## Requirements
- R1: While mrst is high on a wr_clk edge with ld_sel low, both offsets load 127 (each low byte 7Fh, each high byte 00h). Both byte pointers return to the empty-offset low byte.
- R2: While mrst is high on a wr_clk edge with ld_sel high, both offsets load 1023 (each low byte FFh, each high byte 03h).
- R3: A parallel write is ld_sel=0, wr_en_n=0, rd_en_n=1, ser_en_n=1 at a wr_clk edge. It stores din[7:0] into the next byte in this order: empty low, empty high, full low, full high. After full high it wraps back to empty low.
- R4: din[8] is never stored, and rb_byte[8] is always 0.
- R5: A read-back is ld_sel=0, wr_en_n=1, rd_en_n=0, ser_en_n=1 at a rd_clk edge. It places the next byte on rb_byte[7:0] after that edge, in the R3 order, and wraps in the same way. rb_byte holds its value on every other rd_clk edge.
- R6: A serial shift is ld_sel=0, wr_en_n=1, rd_en_n=1, ser_en_n=0 at a wr_clk edge. Thirty-two shifts fill all bytes. The first bit lands in empty-offset bit 0 and the last bit lands in full-offset bit 15.
- R7: ser_en_n sampled low during master reset selects serial programming, and high selects parallel. A write of the method that was not selected leaves both offsets unchanged.
- R8: Read-back works in both programming methods.
- R9: mem_wr is high in the wr_clk cycle after an edge that sees ld_sel=1 and wr_en_n=0, and low otherwise. mem_rd behaves the same way on rd_clk with ld_sel=1 and rd_en_n=0.
- R10: Memory accesses and the no-operation state (ld_sel=1 with both enables high) leave both offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock: parallel writes, serial shifts, memory write strobe |
| rd_clk | input | 1 | Read-side clock: read-back and memory read strobe |
| mrst | input | 1 | Master reset, synchronous and active high, seen on both clocks |
| ld_sel | input | 1 | Low selects offset programming; high selects memory access; sampled at reset to pick the defaults |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| ser_en_n | input | 1 | Serial enable, active low; sampled at reset to pick the method |
| ser_din | input | 1 | Serial data bit |
| din | input | 9 | Parallel data bus; only bits 7:0 are used |
| empty_off | output | 16 | Almost-empty offset |
| full_off | output | 16 | Almost-full offset |
| rb_byte | output | 9 | Read-back byte |
| mem_wr | output | 1 | Registered memory write strobe |
| mem_rd | output | 1 | Registered memory read strobe |

## Verification
A write pointer that slips or wraps in the wrong place puts a byte into the wrong half of an offset. That shows up on empty_off or full_off one wr_clk cycle after the write. A read pointer that is out of step gives a wrong byte on rb_byte on the very next read, and the 9-bit bus has to wrap on the fifth access. A mode flag that was latched wrongly at reset lets an ignored write change an offset in the following cycle. A serial chain shifted in the wrong direction only shows up once all 32 bits are in, as a byte-reversed or bit-reversed pair of offsets.

// File: rtl/fol_pkg.sv
package fol_pkg;
  // decoded meaning of the shared control pins
  typedef struct packed {
    logic pwr;    // parallel byte write into offsets
    logic prd;    // parallel byte read-back
    logic shift;  // serial bit shift
    logic mwr;    // FIFO memory write
    logic mrd;    // FIFO memory read
  } fol_ctl_t;
endpackage

// File: rtl/fol_decode.sv
module fol_decode
  import fol_pkg::*;
(
  input  logic     ld_sel,
  input  logic     wr_en_n,
  input  logic     rd_en_n,
  input  logic     ser_en_n,
  output fol_ctl_t ctl
);
  always_comb begin
    ctl.pwr   = !ld_sel && !wr_en_n &&  rd_en_n &&  ser_en_n;
    ctl.prd   = !ld_sel &&  wr_en_n && !rd_en_n &&  ser_en_n;
    ctl.shift = !ld_sel &&  wr_en_n &&  rd_en_n && !ser_en_n;
    ctl.mwr   =  ld_sel && !wr_en_n;
    ctl.mrd   =  ld_sel && !rd_en_n;
  end
endmodule

// File: rtl/fol_offset_regs.sv
module fol_offset_regs #(
  parameter int BYTE_W = 8,
  parameter int NOFF   = 2,
  parameter int BPO    = 2,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_sel,
  input  logic                          ser_sel_n,
  input  logic                          pwr,
  input  logic                          shift,
  input  logic                          ser_din,
  input  logic [BYTE_W-1:0]             din,
  output logic [NOFF*BPO*BYTE_W-1:0]    chain
);
  localparam int NBYTES  = NOFF * BPO;
  localparam int CHAIN_W = NBYTES * BYTE_W;
  localparam int OFF_W   = BPO * BYTE_W;
  localparam int PTR_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0] wptr;
  logic             ser_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= ld_sel ? {NOFF{OFF_W'(DEF_HI)}} : {NOFF{OFF_W'(DEF_LO)}};
      wptr     <= '0;
      ser_mode <= ~ser_sel_n;
    end else if (pwr && !ser_mode) begin
      chain[wptr*BYTE_W +: BYTE_W] <= din;
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end else if (shift && ser_mode) begin
      chain <= {ser_din, chain[CHAIN_W-1:1]};
    end
  end
endmodule

// File: rtl/fol_readback.sv
module fol_readback #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  parameter int BUS_W  = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       prd,
  input  logic [NBYTES*BYTE_W-1:0]   bytes_i,
  output logic [BUS_W-1:0]           rb_o
);
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0] rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr <= '0;
      rb_o <= '0;
    end else if (prd) begin
      rb_o <= {{(BUS_W-BYTE_W){1'b0}}, bytes_i[rptr*BYTE_W +: BYTE_W]};
      rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_offset_loader.sv
module fifo_offset_loader
  import fol_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 9,
  parameter int BPO    = 2,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic                  wr_clk,
  input  logic                  rd_clk,
  input  logic                  mrst,
  input  logic                  ld_sel,
  input  logic                  wr_en_n,
  input  logic                  rd_en_n,
  input  logic                  ser_en_n,
  input  logic                  ser_din,
  input  logic [BUS_W-1:0]      din,
  output logic [BPO*BYTE_W-1:0] empty_off,
  output logic [BPO*BYTE_W-1:0] full_off,
  output logic [BUS_W-1:0]      rb_byte,
  output logic                  mem_wr,
  output logic                  mem_rd
);
  localparam int NOFF    = 2;
  localparam int OFF_W   = BPO * BYTE_W;
  localparam int NBYTES  = NOFF * BPO;
  localparam int CHAIN_W = NBYTES * BYTE_W;

  fol_ctl_t           ctl;
  logic [CHAIN_W-1:0] chain;
  logic               unused_din_hi;

  assign unused_din_hi = ^din[BUS_W-1:BYTE_W];

  fol_decode u_dec (
    .ld_sel   (ld_sel),
    .wr_en_n  (wr_en_n),
    .rd_en_n  (rd_en_n),
    .ser_en_n (ser_en_n),
    .ctl      (ctl)
  );

  fol_offset_regs #(
    .BYTE_W (BYTE_W), .NOFF (NOFF), .BPO (BPO),
    .DEF_LO (DEF_LO), .DEF_HI (DEF_HI)
  ) u_regs (
    .clk       (wr_clk),
    .rst       (mrst),
    .ld_sel    (ld_sel),
    .ser_sel_n (ser_en_n),
    .pwr       (ctl.pwr),
    .shift     (ctl.shift),
    .ser_din   (ser_din),
    .din       (din[BYTE_W-1:0]),
    .chain     (chain)
  );

  fol_readback #(
    .BYTE_W (BYTE_W), .NBYTES (NBYTES), .BUS_W (BUS_W)
  ) u_rb (
    .clk     (rd_clk),
    .rst     (mrst),
    .prd     (ctl.prd),
    .bytes_i (chain),
    .rb_o    (rb_byte)
  );

  assign empty_off = chain[OFF_W-1:0];
  assign full_off  = chain[2*OFF_W-1:OFF_W];

  always_ff @(posedge wr_clk) begin
    if (mrst) mem_wr <= 1'b0;
    else      mem_wr <= ctl.mwr;
  end

  always_ff @(posedge rd_clk) begin
    if (mrst) mem_rd <= 1'b0;
    else      mem_rd <= ctl.mrd;
  end
endmodule

// File: rtl/fol_checker.sv
module fol_checker #(
  parameter int BYTE_W = 8,
  parameter int BUS_W  = 9,
  parameter int BPO    = 2,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input logic                  wr_clk,
  input logic                  rd_clk,
  input logic                  mrst,
  input logic                  ld_sel,
  input logic                  wr_en_n,
  input logic                  rd_en_n,
  input logic                  ser_en_n,
  input logic [BPO*BYTE_W-1:0] empty_off,
  input logic [BPO*BYTE_W-1:0] full_off,
  input logic [BUS_W-1:0]      rb_byte,
  input logic                  mem_wr,
  input logic                  mem_rd
);
  localparam int OFF_W = BPO * BYTE_W;

  AST_RESET_EQUAL: assert property (@(posedge wr_clk) disable iff (mrst)
    $past(mrst) |-> (empty_off == full_off)); // R1

  AST_RESET_VALUE: assert property (@(posedge wr_clk) disable iff (mrst)
    $past(mrst) |-> (empty_off == OFF_W'(DEF_LO) || empty_off == OFF_W'(DEF_HI))); // R2

  AST_RB_TOP_ZERO: assert property (@(posedge rd_clk) disable iff (mrst)
    rb_byte[BUS_W-1:BYTE_W] == '0); // R4

  AST_RB_HOLD: assert property (@(posedge rd_clk) disable iff (mrst)
    !(!ld_sel && wr_en_n && !rd_en_n && ser_en_n) |=> $stable(rb_byte)); // R5

  AST_MEMWR_SET: assert property (@(posedge wr_clk) disable iff (mrst)
    (ld_sel && !wr_en_n) |=> mem_wr); // R9

  AST_MEMWR_CLR: assert property (@(posedge wr_clk) disable iff (mrst)
    !(ld_sel && !wr_en_n) |=> !mem_wr); // R9

  AST_MEMRD_SET: assert property (@(posedge rd_clk) disable iff (mrst)
    (ld_sel && !rd_en_n) |=> mem_rd); // R9

  AST_OFF_HOLD: assert property (@(posedge wr_clk) disable iff (mrst)
    ld_sel |=> ($stable(empty_off) && $stable(full_off))); // R10
endmodule

bind fifo_offset_loader fol_checker #(
  .BYTE_W (BYTE_W), .BUS_W (BUS_W), .BPO (BPO),
  .DEF_LO (DEF_LO), .DEF_HI (DEF_HI)
) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .mrst      (mrst),
  .ld_sel    (ld_sel),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .ser_en_n  (ser_en_n),
  .empty_off (empty_off),
  .full_off  (full_off),
  .rb_byte   (rb_byte),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd)
);

// File: tb/sim_fifo_offset_loader.sv
module sim_fifo_offset_loader;
  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic       ld_sel = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1, ser_en_n = 1'b1;
  logic       ser_din = 1'b0;
  logic [8:0] din = '0;
  logic [15:0] empty_off, full_off;
  logic [8:0]  rb_byte;
  logic        mem_wr, mem_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fifo_offset_loader u0 (
    .wr_clk (clk), .rd_clk (clk), .mrst (mrst),
    .ld_sel (ld_sel), .wr_en_n (wr_en_n), .rd_en_n (rd_en_n),
    .ser_en_n (ser_en_n), .ser_din (ser_din), .din (din),
    .empty_off (empty_off), .full_off (full_off), .rb_byte (rb_byte),
    .mem_wr (mem_wr), .mem_rd (mem_rd)
  );

  // {din, expected empty_off, expected full_off} after each parallel write
  localparam logic [40:0] VEC [6] = '{
    {9'h1A5, 16'h00A5, 16'h007F},  // R3 empty low; R4 bit 8 dropped
    {9'h012, 16'h12A5, 16'h007F},  // R3 empty high
    {9'h134, 16'h12A5, 16'h0034},  // R3 full low
    {9'h056, 16'h12A5, 16'h5634},  // R3 full high
    {9'h0EE, 16'h12EE, 16'h5634},  // R3 wrap to empty low
    {9'h1FF, 16'hFFEE, 16'h5634}   // R3 then empty high
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_sel = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; ser_en_n = 1'b1;
  endtask

  task automatic do_reset(input logic ld, input logic sen_n);
    @(negedge clk);
    mrst = 1'b1; ld_sel = ld; ser_en_n = sen_n; wr_en_n = 1'b1; rd_en_n = 1'b1;
    repeat (2) @(negedge clk);
    mrst = 1'b0; idle();
  endtask

  // one-cycle operation; returns at the following negedge with outputs updated
  task automatic op(input logic ld, input logic wn, input logic rn, input logic sn,
                    input logic sd, input logic [8:0] d);
    @(negedge clk);
    ld_sel = ld; wr_en_n = wn; rd_en_n = rn; ser_en_n = sn; ser_din = sd; din = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] e0, f0;
    logic [31:0] pat;
    // parallel method, low defaults
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk("R1 empty default", 32'(empty_off), 32'h007F);
    chk("R1 full default", 32'(full_off), 32'h007F);
    chk("R1 rb reset", 32'(rb_byte), 32'h0);
    chk("R9 strobes idle", {mem_wr, mem_rd}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, VEC[i][40:32]);
      chk("R3 empty_off", 32'(empty_off), 32'(VEC[i][31:16]));
      chk("R3 full_off", 32'(full_off), 32'(VEC[i][15:0]));
    end

    // read-back order and wrap: bytes EE FF 34 56 EE
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R5 rb empty low", 32'(rb_byte), 32'h0EE);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R5 rb empty high", 32'(rb_byte), 32'h0FF);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R5 rb full low", 32'(rb_byte), 32'h034);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R5 rb full high", 32'(rb_byte), 32'h056);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R5 rb wrap", 32'(rb_byte), 32'h0EE);
    chk("R4 rb bit8 zero", 32'(rb_byte[8]), 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 rb holds", 32'(rb_byte), 32'h0EE);

    // memory strobes and offsets untouched
    e0 = empty_off; f0 = full_off;
    @(negedge clk);
    ld_sel = 1'b1; wr_en_n = 1'b0; din = 9'h0AA;
    @(negedge clk);
    chk("R9 mem_wr high", 32'(mem_wr), 32'h1);
    chk("R9 mem_rd low", 32'(mem_rd), 32'h0);
    idle(); rd_en_n = 1'b0;
    @(negedge clk);
    chk("R9 mem_rd high", 32'(mem_rd), 32'h1);
    chk("R9 mem_wr low", 32'(mem_wr), 32'h0);
    idle();
    @(negedge clk);
    chk("R9 strobes clear", {mem_wr, mem_rd}, 32'h0);
    chk("R10 offsets kept", {empty_off, full_off}, {e0, f0});

    // serial shift ignored in parallel method
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9'h0);
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0);
    chk("R7 shift ignored", {empty_off, full_off}, {e0, f0});

    // high defaults, pointers return to start
    do_reset(1'b1, 1'b1);
    @(negedge clk);
    chk("R2 empty default", 32'(empty_off), 32'h03FF);
    chk("R2 full default", 32'(full_off), 32'h03FF);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R1 rptr reset", 32'(rb_byte), 32'h0FF);
    op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h011);
    chk("R1 wptr reset", 32'(empty_off), 32'h0311);

    // serial method
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk("R7 serial defaults", {empty_off, full_off}, {16'h007F, 16'h007F});
    op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h055);
    chk("R7 parallel ignored", {empty_off, full_off}, {16'h007F, 16'h007F});
    pat = 32'hC3A5_5A3C;
    for (int b = 0; b < 32; b++) op(1'b0, 1'b1, 1'b1, 1'b0, pat[b], 9'h0);
    chk("R6 serial empty", 32'(empty_off), 32'h5A3C);
    chk("R6 serial full", 32'(full_off), 32'hC3A5);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R8 rb in serial", 32'(rb_byte), 32'h03C);
    op(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0);
    chk("R8 rb in serial 2", 32'(rb_byte), 32'h05A);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule